// File: doc/BRIEF.md
# Match Timer with Cross-Domain Access Tracking

The block is an operating-system tick timer placed behind a simple register interface. A 32-bit counter advances by one on each pulse of a tick-enable input, which stands for the slow timer clock of about 3 MHz. A programmable match value is compared against the counter. When the counter reaches the match value, a sticky flag is raised, and the flag drives an interrupt line if the enable bit allows it.

Software does not touch the counter or the match value directly. Each access passes through a tracked transfer that takes a fixed number of timer ticks. A snapshot of the counter is requested through the control register and read back once it is ready. Writes to the counter and to the match value are staged and applied later. A busy bit for each kind of transfer shows software when it may read or write again. Register offsets in bytes are: match value 0x00, counter snapshot and load 0x10, flags 0x14, interrupt enable 0x1C, control 0x20, transfer busy 0x24. Reads from any other offset return zero.

Top module: `tick_match_timer`

## Requirements
- R1: After reset, offset 0x00 reads 0xFFFFFFFF. Offsets 0x10, 0x14, 0x1C, 0x20 and 0x24 read 0, and irqOut is 0.
- R2: When control bit 0 is 1, the counter advances by one on every tick and wraps from 0xFFFFFFFF to 0. When control bit 0 is 0, ticks leave the counter unchanged.
- R3: A control write with bit 1 set (for example the value 3) requests a snapshot and sets busy bit 5 at 0x24. On the third tick after the request, the counter value present just before that tick's increment is captured. Bit 5 reads 0 from the next cycle, and offset 0x10 returns the captured value.
- R4: A write to 0x10 sets busy bit 4. On the third tick after the write, the counter is loaded with the written value, and that tick does not increment it. Bit 4 then reads 0.
- R5: A write to 0x00 sets busy bit 0. On the third tick after the write, the match value takes the written data, which 0x00 then reads back, and bit 0 clears.
- R6: A write to 0x10 or 0x00, or a snapshot request, issued while its own busy bit is 1 is dropped. Control bit 0 is still updated by a control write made during a busy snapshot.
- R7: On a counting tick where the incremented counter equals the match value, flag bit 0 at 0x14 reads 1 from the next cycle. Flag bits 3:1 always read 0.
- R8: Writing 1 to bit 0 of 0x14 clears the flag, and writing 0 to that bit leaves it as it is. A match and a clear in the same cycle leave the flag at 1.
- R9: irqOut is 1 exactly when flag bit 0 is 1 and bit 0 of 0x1C is 1.
- R10: A match value placed any distance of 1 tick or more past the counter value at which the match write completes produces the flag on the tick the counter reaches it. This includes the short distance of 16 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | One-cycle pulse per timer tick |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 8 | Byte offset of the access |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| irqOut | output | 1 | Match interrupt |

## Verification
Counter snapshots are taken after different numbers of ticks. This separates a correct capture point from a capture that is one tick early or late, and from a count that does not advance. A counter load just below the all-ones value, followed by snapshots, tells correct wrap-around apart from saturation or a lost load tick. Match distances are swept from 1 to 20 ticks past the point where the match write completes, and the flag is checked both one tick before the expected match and on the match tick itself. This separates an exact compare from an early, late or missing one. Back-to-back writes made while a transfer is busy, and a clear that lands on the same cycle as a match, show whether dropped writes and flag priority are handled correctly.

// File: rtl/tmt_pkg.sv
package tmt_pkg;
  localparam int CNT_W  = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_MATCH = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_COUNT = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_FLAGS = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_IEN   = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_BUSY  = 8'h24;

  // transfer channel indices
  localparam int CH_MATCH = 0;
  localparam int CH_LOAD  = 1;
  localparam int CH_SNAP  = 2;
  localparam int NUM_CH   = 3;

  typedef struct packed {
    logic             countEn;
    logic             cntLoad;
    logic [CNT_W-1:0] cntLoadVal;
    logic             matchLoad;
    logic [CNT_W-1:0] matchLoadVal;
    logic             snapTake;
    logic             flagClr;
  } tmtStrobes_t;
endpackage

// File: rtl/tmt_ctrl.sv
module tmt_ctrl
  import tmt_pkg::*;
#(
  parameter int SYNC_TICKS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWrData,
  output tmtStrobes_t       strobes,
  output logic              intEnable,
  output logic              countEnable,
  output logic [NUM_CH-1:0] busy
);
  localparam int TW = $clog2(SYNC_TICKS + 1);
  localparam logic [TW-1:0] LAST_TICK = TW'(SYNC_TICKS - 1);

  logic wrMatch, wrCount, wrFlags, wrIen, wrCtrl;
  logic [NUM_CH-1:0] request, start, done;
  logic [CNT_W-1:0] matchPend, cntPend;

  assign wrMatch = busWrEn && (busAddr == OFS_MATCH);
  assign wrCount = busWrEn && (busAddr == OFS_COUNT);
  assign wrFlags = busWrEn && (busAddr == OFS_FLAGS);
  assign wrIen   = busWrEn && (busAddr == OFS_IEN);
  assign wrCtrl  = busWrEn && (busAddr == OFS_CTRL);

  assign request[CH_MATCH] = wrMatch;
  assign request[CH_LOAD]  = wrCount;
  assign request[CH_SNAP]  = wrCtrl && busWrData[1];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [TW-1:0] tickCnt;
    assign start[ch] = request[ch] && !busy[ch];
    assign done[ch]  = busy[ch] && tickEn && (tickCnt == LAST_TICK);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        busy[ch] <= 1'b0;
        tickCnt  <= '0;
      end else if (start[ch]) begin
        busy[ch] <= 1'b1;
        tickCnt  <= '0;
      end else if (busy[ch] && tickEn) begin
        if (tickCnt == LAST_TICK) begin
          busy[ch] <= 1'b0;
        end else begin
          tickCnt <= tickCnt + 1'b1;
        end
      end
    end

    assert_busy_releases_R3: assert property (@(posedge clk) disable iff (!rstN)
      done[ch] |=> !busy[ch]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchPend   <= '0;
      cntPend     <= '0;
      intEnable   <= 1'b0;
      countEnable <= 1'b0;
    end else begin
      if (start[CH_MATCH]) matchPend <= busWrData;
      if (start[CH_LOAD])  cntPend   <= busWrData;
      if (wrIen)           intEnable <= busWrData[0];
      if (wrCtrl)          countEnable <= busWrData[0];
    end
  end

  always_comb begin
    strobes.countEn      = countEnable;
    strobes.cntLoad      = done[CH_LOAD];
    strobes.cntLoadVal   = cntPend;
    strobes.matchLoad    = done[CH_MATCH];
    strobes.matchLoadVal = matchPend;
    strobes.snapTake     = done[CH_SNAP];
    strobes.flagClr      = wrFlags && busWrData[0];
  end

  // R6: staged values do not move when a write arrives during a busy transfer
  assert_match_drop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy[CH_MATCH] && wrMatch) |=> $stable(matchPend));
  assert_load_drop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy[CH_LOAD] && wrCount) |=> $stable(cntPend));
endmodule

// File: rtl/tmt_datapath.sv
module tmt_datapath
  import tmt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  tmtStrobes_t      strobes,
  output logic [CNT_W-1:0] snapshot,
  output logic [CNT_W-1:0] matchVal,
  output logic             matchFlag
);
  logic [CNT_W-1:0] counter;
  logic [CNT_W-1:0] counterInc;
  logic             stepping;
  logic             hit;

  assign counterInc = counter + 1'b1;
  assign stepping   = tickEn && strobes.countEn && !strobes.cntLoad;
  assign hit        = stepping && (counterInc == matchVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      counter   <= '0;
      snapshot  <= '0;
      matchVal  <= '1;
      matchFlag <= 1'b0;
    end else begin
      if (strobes.cntLoad)       counter <= strobes.cntLoadVal;
      else if (stepping)         counter <= counterInc;
      if (strobes.snapTake)      snapshot <= counter;
      if (strobes.matchLoad)     matchVal <= strobes.matchLoadVal;
      if (hit)                   matchFlag <= 1'b1;
      else if (strobes.flagClr)  matchFlag <= 1'b0;
    end
  end

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && strobes.countEn && !strobes.cntLoad) |=> (counter == $past(counter) + 1'b1));
  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!(tickEn && strobes.countEn) && !strobes.cntLoad) |=> $stable(counter));
  assert_count_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.cntLoad |=> (counter == $past(strobes.cntLoadVal)));
  assert_flag_on_hit_R7: assert property (@(posedge clk) disable iff (!rstN)
    hit |=> matchFlag);
endmodule

// File: rtl/tick_match_timer.sv
module tick_match_timer
  import tmt_pkg::*;
#(
  parameter int SYNC_TICKS = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic        busWrEn,
  input  logic [7:0]  busAddr,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  output logic        irqOut
);
  tmtStrobes_t       strobes;
  logic              intEnable, countEnable, matchFlag;
  logic [NUM_CH-1:0] busy;
  logic [CNT_W-1:0]  snapshot, matchVal;

  tmt_ctrl #(.SYNC_TICKS(SYNC_TICKS)) ctrl_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .strobes(strobes),
    .intEnable(intEnable), .countEnable(countEnable), .busy(busy)
  );

  tmt_datapath dp_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strobes(strobes),
    .snapshot(snapshot), .matchVal(matchVal), .matchFlag(matchFlag)
  );

  assign irqOut = matchFlag && intEnable;

  always_comb begin
    busRdData = '0;
    case (busAddr)
      OFS_MATCH: busRdData = matchVal;
      OFS_COUNT: busRdData = snapshot;
      OFS_FLAGS: busRdData[0] = matchFlag;
      OFS_IEN:   busRdData[0] = intEnable;
      OFS_CTRL:  busRdData[0] = countEnable;
      OFS_BUSY: begin
        busRdData[5] = busy[CH_SNAP];
        busRdData[4] = busy[CH_LOAD];
        busRdData[0] = busy[CH_MATCH];
      end
      default:   busRdData = '0;
    endcase
  end

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> (matchFlag && intEnable));
endmodule

// File: tb/tick_match_timer_tb_top.sv
module tick_match_timer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        irqOut;

  int nVec = 0;
  int nFail = 0;
  logic [31:0] model = '0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  tick_match_timer dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nVec++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    tickEn = 1'b1;
    @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    busAddr = a;
    #1 v = busRdData;
  endtask

  // snapshot request followed by three counting ticks; counter enabled
  task automatic snapCheck(input string req);
    logic [31:0] exp;
    exp = model + 32'd2;
    wr(8'h20, 32'd3);
    rd(8'h24, rv); chk({req, " busy5 set"}, rv, 32'h20);
    for (int i = 0; i < 3; i++) tick();
    model = model + 32'd3;
    rd(8'h24, rv); chk({req, " busy5 clear"}, rv, 32'h0);
    rd(8'h10, rv); chk({req, " snapshot"}, rv, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(8'h00, rv); chk("R1 match", rv, 32'hFFFFFFFF);
    rd(8'h10, rv); chk("R1 count", rv, 0);
    rd(8'h14, rv); chk("R1 flags", rv, 0);
    rd(8'h1C, rv); chk("R1 ien", rv, 0);
    rd(8'h20, rv); chk("R1 ctrl", rv, 0);
    rd(8'h24, rv); chk("R1 busy", rv, 0);
    chk("R1 irq", {31'b0, irqOut}, 0);

    // R2 hold while disabled, R3 snapshot without enable
    for (int i = 0; i < 5; i++) tick();
    wr(8'h20, 32'd2);
    rd(8'h24, rv); chk("R3 busy5", rv, 32'h20);
    tick(); tick();
    rd(8'h24, rv); chk("R3 busy5 after 2 ticks", rv, 32'h20);
    tick();
    rd(8'h24, rv); chk("R3 busy5 after 3 ticks", rv, 0);
    rd(8'h10, rv); chk("R2 disabled hold", rv, 0);
    rd(8'h20, rv); chk("R2 ctrl stays off", rv, 0);

    // R2/R3 counting sweep with varied gaps
    wr(8'h20, 32'd1);
    for (int g = 0; g < 6; g++) begin
      for (int i = 0; i < g; i++) tick();
      model = model + 32'(g);
      snapCheck("R3 sweep");
    end

    // R4 load near the top, R2 wrap
    wr(8'h10, 32'hFFFFFFFE);
    rd(8'h24, rv); chk("R4 busy4", rv, 32'h10);
    tick(); tick(); tick();
    model = 32'hFFFFFFFE;
    rd(8'h24, rv); chk("R4 busy4 clear", rv, 0);
    snapCheck("R2 wrap");
    snapCheck("R2 after wrap");

    // R6 dropped second count write
    wr(8'h10, 32'h100);
    wr(8'h10, 32'h5);
    tick(); tick(); tick();
    model = 32'h100;
    snapCheck("R6 count drop");

    // R6 snapshot request while busy is dropped, enable still updates
    wr(8'h20, 32'd3);
    wr(8'h20, 32'd2);
    rd(8'h20, rv); chk("R6 ctrl enable updated", rv, 0);
    tick(); tick(); tick();
    rd(8'h10, rv); chk("R6 snapshot while disabled", rv, model + 32'd0);
    wr(8'h20, 32'd1);

    // R5 match staging and R6 dropped second match write
    wr(8'h00, 32'h50);
    rd(8'h24, rv); chk("R5 busy0", rv, 32'h1);
    wr(8'h00, 32'h60);
    tick(); tick();
    model = model + 32'd2;
    rd(8'h00, rv); chk("R5 match not yet applied", rv, 32'hFFFFFFFF);
    tick();
    model = model + 32'd1;
    rd(8'h24, rv); chk("R5 busy0 clear", rv, 0);
    rd(8'h00, rv); chk("R6 match drop", rv, 32'h50);

    // R7/R9/R10 match distance sweep
    wr(8'h1C, 32'd1);
    for (int d = 1; d <= 20; d++) begin
      logic [31:0] tgt;
      wr(8'h14, 32'hF);
      tgt = model + 32'd3 + 32'(d);
      wr(8'h00, tgt);
      tick(); tick(); tick();
      model = model + 32'd3;
      for (int i = 0; i < d - 1; i++) tick();
      model = model + 32'(d - 1);
      rd(8'h14, rv); chk("R10 no early flag", rv, 0);
      chk("R9 irq low before match", {31'b0, irqOut}, 0);
      tick();
      model = model + 32'd1;
      rd(8'h14, rv); chk("R7 flag on match", rv, 32'h1);
      chk("R9 irq on match", {31'b0, irqOut}, 1);
    end

    // R9 enable gate, R8 clear behaviour
    wr(8'h1C, 32'd0);
    chk("R9 irq masked", {31'b0, irqOut}, 0);
    wr(8'h14, 32'hE);
    rd(8'h14, rv); chk("R8 write 0 keeps flag", rv, 32'h1);
    wr(8'h14, 32'h1);
    rd(8'h14, rv); chk("R8 clear", rv, 0);
    wr(8'h1C, 32'd1);
    chk("R9 irq stays low", {31'b0, irqOut}, 0);

    // R8 match and clear in the same cycle
    wr(8'h00, model + 32'd5);
    tick(); tick(); tick();
    model = model + 32'd3;
    tick();
    model = model + 32'd1;
    @(negedge clk);
    tickEn = 1'b1; busWrEn = 1'b1; busAddr = 8'h14; busWrData = 32'h1;
    @(negedge clk);
    tickEn = 1'b0; busWrEn = 1'b0;
    model = model + 32'd1;
    rd(8'h14, rv); chk("R8 set wins", rv, 32'h1);
    chk("R9 irq after set wins", {31'b0, irqOut}, 1);
    rd(8'h30, rv); chk("R1 unmapped reads zero", rv, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end
endmodule